// File: doc/BRIEF.md
# Calendar Clock with Two-Phase Update Cycle

This block keeps wall-clock time and date (seconds, minutes, hours, weekday, day of month, month and two-digit year) and publishes them as byte-wide display registers. A 32768 Hz enable feeds a divider that produces a one-second tick. At the tick, the internal binary time advances by one second and an update-in-progress flag is raised. A fixed number of 32 kHz ticks later, the display registers are refreshed from the internal time, the flag drops, and optional end-of-update and alarm-check strobes are issued for the interrupt logic that sits outside this block.

A control byte chooses the display encoding (packed decimal or plain binary) and the hour form (24-hour, or 12-hour with a PM flag in bit 7). A second control byte holds the oscillator select field. Host writes to any time register store the byte and, unless the freeze bit is on, rebuild the internal time from the registers. The freeze bit stops refreshes so that the host can program all fields and then release them together.

Top module: `calendar_clock`

## Requirements
- R1: After reset the time registers read sec 00, min 00, hour 00, weekday 00, day 01, month 01, year 00; control A (address 7) reads 0x26; control B (address 8) reads 0x02; both strobes are low.
- R2: Each second tick, taken every TICKS_PER_SEC enables, raises UIP (control A bit 7) for exactly COPY_TICKS enables. The registers keep the old time while UIP is high and show the new time in the cycle UIP falls.
- R3: The clock advances only while control A bits 6:4 equal 010. With any other value no tick raises UIP and the registers stay unchanged.
- R4: UIP (control A bit 7) cannot be written. Control A bits 6:0 keep the written value.
- R5: With control B bit 2 clear, each field is shown as packed decimal (tens in bits 7:4, units in 3:0). Seconds roll at 60 into minutes, minutes at 60 into hours, and hours at 24 into the day. The day rolls past the month length into the month, and month 12 rolls into month 1 of the next year, with the year shown modulo 100.
- R6: With control B bit 2 set, every field is shown and loaded as a plain binary value.
- R7: With control B bit 1 clear (12-hour form), the shown hour is the hour mod 12, with bit 7 set for hours 12 to 23. A loaded hour byte is decoded from bits 6:0, and 12 is added when bit 7 is set.
- R8: February has 29 days when the full year (register year plus 2000 on load) is divisible by 4 and either not by 100 or by 400. April, June, September and November have 30 days.
- R9: While control B bit 7 (freeze) is set, UIP stays low and the time registers hold their written values. Clearing the bit reloads the internal time from the registers.
- R10: A host write to a time register (address 0 sec, 1 min, 2 hour, 3 weekday, 4 day, 5 month, 6 year) with freeze clear reloads the internal time from all registers, so the next update shows the written time plus one second.
- R11: At the end of each update, `updEnd` pulses for one cycle when control B bit 4 is set, and `alarmChk` pulses for one cycle when control B bit 5 is set. The pulses coincide with the register refresh.
- R12: The weekday wraps from 6 to 0 at the day rollover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick32k | input | 1 | 32768 Hz enable, one cycle wide |
| wrEn | input | 1 | Host register write strobe |
| wrAddr | input | 4 | Host register address (0-6 time, 7 control A, 8 control B) |
| wrData | input | 8 | Host write data |
| secReg | output | 8 | Seconds register |
| minReg | output | 8 | Minutes register |
| hourReg | output | 8 | Hours register (bit 7 PM in 12-hour form) |
| wdayReg | output | 8 | Day-of-week register |
| mdayReg | output | 8 | Day-of-month register |
| monReg | output | 8 | Month register |
| yearReg | output | 8 | Year register (year mod 100) |
| ctlA | output | 8 | Control A: UIP in bit 7, oscillator select in 6:4 |
| ctlB | output | 8 | Control B: freeze, strobe enables, encoding, hour form |
| updEnd | output | 1 | End-of-update strobe |
| alarmChk | output | 1 | Alarm-check strobe |

## Verification
The bench goes after the full date rollover on New Year's Eve at 23:59:59 on a Saturday, where a wrong carry chain would leave a stale month or year, or a weekday of 7. It covers February 28 in 2000, 2024 and 2023, and the 30-day April end, to catch a leap rule that ignores the century clause or a wrong month table. The 11 AM and 11 PM transitions in 12-hour form show whether noon is flagged PM and midnight is shown as hour 0. A design that dropped the PM offset on load would roll a PM time into the wrong day. Freeze and the oscillator field are checked by watching that nothing moves over several seconds, and that release reloads from the frozen bytes instead of the hidden advanced time.

// File: rtl/calclk_pkg.sv
package calclk_pkg;

  // host register addresses
  localparam logic [3:0] ADR_SEC  = 4'd0;
  localparam logic [3:0] ADR_MIN  = 4'd1;
  localparam logic [3:0] ADR_HOUR = 4'd2;
  localparam logic [3:0] ADR_WDAY = 4'd3;
  localparam logic [3:0] ADR_MDAY = 4'd4;
  localparam logic [3:0] ADR_MON  = 4'd5;
  localparam logic [3:0] ADR_YEAR = 4'd6;
  localparam logic [3:0] ADR_CTLA = 4'd7;
  localparam logic [3:0] ADR_CTLB = 4'd8;

  // control B bit positions
  localparam int B_FRZ = 7;
  localparam int B_AIE = 5;
  localparam int B_UIE = 4;
  localparam int B_BIN = 2;
  localparam int B_H24 = 1;

  typedef enum logic {PH_IDLE, PH_WAIT} phase_t;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic advance;
    logic copyOut;
  } stepCmd_t;

  typedef struct packed {
    logic [7:0] sec;
    logic [7:0] min;
    logic [7:0] hour;
    logic [7:0] wday;
    logic [7:0] mday;
    logic [7:0] mon;
    logic [7:0] year;
  } calTime_t;

  function automatic logic [7:0] fromDisp(input logic [7:0] v, input logic bin);
    logic [7:0] dec;
    dec = 8'(v[7:4]) * 8'd10 + 8'(v[3:0]);
    return bin ? v : dec;
  endfunction

  function automatic logic [7:0] toDisp(input logic [7:0] v, input logic bin);
    logic [7:0] tens;
    logic [7:0] units;
    tens  = v / 8'd10;
    units = v % 8'd10;
    return bin ? v : {tens[3:0], units[3:0]};
  endfunction

  // yr counts from 1900
  function automatic logic isLeap(input logic [7:0] yr);
    logic [11:0] full;
    full = 12'(yr) + 12'd1900;
    return (full % 12'd4 == 12'd0) &&
           ((full % 12'd100 != 12'd0) || (full % 12'd400 == 12'd0));
  endfunction

  // mon is zero based; out-of-range months count 31 days
  function automatic logic [7:0] daysIn(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'd1:                      return isLeap(yr) ? 8'd29 : 8'd28;
      8'd3, 8'd5, 8'd8, 8'd10:   return 8'd30;
      default:                   return 8'd31;
    endcase
  endfunction

endpackage

// File: rtl/calclk_seq.sv
module calclk_seq
  import calclk_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int COPY_TICKS    = 8
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     tick32k,
  input  logic     oscRun,
  input  logic     freeze,
  input  logic     uie,
  input  logic     aie,
  input  logic     clrUip,
  output stepCmd_t cmd,
  output logic     uip,
  output logic     updEnd,
  output logic     alarmChk
);

  localparam int DIV_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam int CNT_W = (COPY_TICKS > 1) ? $clog2(COPY_TICKS) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST  = DIV_W'(TICKS_PER_SEC - 1);
  localparam logic [CNT_W-1:0] COPY_LAST = CNT_W'(COPY_TICKS - 1);

  logic [DIV_W-1:0] divCnt;
  logic [CNT_W-1:0] waitCnt;
  phase_t           phase;
  logic             secTick;
  logic             lastCopy;

  assign secTick  = tick32k && (divCnt == DIV_LAST);
  assign lastCopy = (phase == PH_WAIT) && tick32k && (waitCnt == COPY_LAST);

  assign cmd.advance = secTick && oscRun && (phase == PH_IDLE);
  assign cmd.copyOut = lastCopy && !freeze;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt   <= '0;
      waitCnt  <= '0;
      phase    <= PH_IDLE;
      uip      <= 1'b0;
      updEnd   <= 1'b0;
      alarmChk <= 1'b0;
    end else begin
      if (tick32k) divCnt <= secTick ? '0 : divCnt + 1'b1;

      if (cmd.advance) begin
        phase   <= PH_WAIT;
        waitCnt <= '0;
      end else if (lastCopy) begin
        phase <= PH_IDLE;
      end else if (phase == PH_WAIT && tick32k) begin
        waitCnt <= waitCnt + 1'b1;
      end

      if (clrUip || lastCopy) uip <= 1'b0;
      else if (cmd.advance)   uip <= !freeze;

      updEnd   <= lastCopy && uie;
      alarmChk <= lastCopy && aie;
    end
  end

endmodule

// File: rtl/calclk_time.sv
module calclk_time
  import calclk_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  stepCmd_t          cmd,
  output calTime_t          dispRegs,
  output logic [6:0]        ctlALow,
  output logic [7:0]        ctlB,
  output logic              clrUip
);

  calTime_t   tNow;
  calTime_t   tNext;
  calTime_t   tLoad;
  calTime_t   view;
  calTime_t   enc;
  logic       binMode;
  logic       h24;
  logic       loadEn;
  logic [7:0] dim;
  logic [7:0] mdayInc;
  logic [7:0] hourLow;

  assign binMode = ctlB[B_BIN];
  assign h24     = ctlB[B_H24];
  assign clrUip  = wrEn && (wrAddr == ADR_CTLB) && wrData[B_FRZ];
  assign loadEn  = wrEn && (((wrAddr <= ADR_YEAR) && !ctlB[B_FRZ]) ||
                            ((wrAddr == ADR_CTLB) && !wrData[B_FRZ] && ctlB[B_FRZ]));

  // registers as they look with the current write merged in
  always_comb begin
    view = dispRegs;
    if (wrEn) begin
      case (wrAddr)
        ADR_SEC:  view.sec  = wrData;
        ADR_MIN:  view.min  = wrData;
        ADR_HOUR: view.hour = wrData;
        ADR_WDAY: view.wday = wrData;
        ADR_MDAY: view.mday = wrData;
        ADR_MON:  view.mon  = wrData;
        ADR_YEAR: view.year = wrData;
        default: ;
      endcase
    end
  end

  // decode display bytes into internal binary time
  always_comb begin
    hourLow    = fromDisp({1'b0, view.hour[6:0]}, binMode);
    tLoad.sec  = fromDisp(view.sec, binMode);
    tLoad.min  = fromDisp(view.min, binMode);
    tLoad.hour = h24 ? fromDisp(view.hour, binMode)
                     : hourLow + (view.hour[7] ? 8'd12 : 8'd0);
    tLoad.wday = fromDisp(view.wday, binMode);
    tLoad.mday = fromDisp(view.mday, binMode);
    tLoad.mon  = fromDisp(view.mon, binMode) - 8'd1;
    tLoad.year = fromDisp(view.year, binMode) + 8'd100;
  end

  // one-second advance with the full carry chain
  always_comb begin
    tNext   = tNow;
    dim     = daysIn(tNow.mon, tNow.year);
    mdayInc = tNow.mday + 8'd1;
    tNext.sec = tNow.sec + 8'd1;
    if (tNext.sec >= 8'd60) begin
      tNext.sec = 8'd0;
      tNext.min = tNow.min + 8'd1;
      if (tNext.min >= 8'd60) begin
        tNext.min  = 8'd0;
        tNext.hour = tNow.hour + 8'd1;
        if (tNext.hour >= 8'd24) begin
          tNext.hour = 8'd0;
          tNext.wday = tNow.wday + 8'd1;
          if (tNext.wday >= 8'd7) tNext.wday = 8'd0;
          tNext.mday = mdayInc;
          if (mdayInc == 8'd0) begin
            tNext.mday = 8'd1;
          end else if (mdayInc > dim) begin
            tNext.mday = 8'd1;
            tNext.mon  = tNow.mon + 8'd1;
            if (tNext.mon >= 8'd12) begin
              tNext.mon  = 8'd0;
              tNext.year = tNow.year + 8'd1;
            end
          end
        end
      end
    end
  end

  // encode internal time for the display registers
  always_comb begin
    enc.sec  = toDisp(tNow.sec, binMode);
    enc.min  = toDisp(tNow.min, binMode);
    enc.hour = h24 ? toDisp(tNow.hour, binMode)
                   : (toDisp(tNow.hour % 8'd12, binMode) |
                      ((tNow.hour >= 8'd12) ? 8'h80 : 8'h00));
    enc.wday = toDisp(tNow.wday, binMode);
    enc.mday = toDisp(tNow.mday, binMode);
    enc.mon  = toDisp(tNow.mon + 8'd1, binMode);
    enc.year = toDisp(tNow.year % 8'd100, binMode);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tNow     <= '{sec: 8'd0, min: 8'd0, hour: 8'd0, wday: 8'd0,
                    mday: 8'd1, mon: 8'd0, year: 8'd100};
      dispRegs <= '{sec: 8'h00, min: 8'h00, hour: 8'h00, wday: 8'h00,
                    mday: 8'h01, mon: 8'h01, year: 8'h00};
      ctlALow  <= 7'h26;
      ctlB     <= 8'h02;
    end else begin
      if (loadEn)           tNow <= tLoad;
      else if (cmd.advance) tNow <= tNext;

      if (cmd.copyOut) dispRegs <= enc;

      if (wrEn) begin
        case (wrAddr)
          ADR_SEC:  dispRegs.sec  <= wrData;
          ADR_MIN:  dispRegs.min  <= wrData;
          ADR_HOUR: dispRegs.hour <= wrData;
          ADR_WDAY: dispRegs.wday <= wrData;
          ADR_MDAY: dispRegs.mday <= wrData;
          ADR_MON:  dispRegs.mon  <= wrData;
          ADR_YEAR: dispRegs.year <= wrData;
          ADR_CTLA: ctlALow       <= wrData[6:0];
          ADR_CTLB: ctlB          <= wrData;
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/calendar_clock.sv
module calendar_clock
  import calclk_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int COPY_TICKS    = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick32k,
  input  logic       wrEn,
  input  logic [3:0] wrAddr,
  input  logic [7:0] wrData,
  output logic [7:0] secReg,
  output logic [7:0] minReg,
  output logic [7:0] hourReg,
  output logic [7:0] wdayReg,
  output logic [7:0] mdayReg,
  output logic [7:0] monReg,
  output logic [7:0] yearReg,
  output logic [7:0] ctlA,
  output logic [7:0] ctlB,
  output logic       updEnd,
  output logic       alarmChk
);

  stepCmd_t   cmd;
  calTime_t   dispRegs;
  logic [6:0] ctlALow;
  logic       clrUip;
  logic       uip;

  calclk_seq #(
    .TICKS_PER_SEC(TICKS_PER_SEC),
    .COPY_TICKS   (COPY_TICKS)
  ) u_seq (
    .clk     (clk),
    .rstN    (rstN),
    .tick32k (tick32k),
    .oscRun  (ctlALow[6:4] == 3'b010),
    .freeze  (ctlB[B_FRZ]),
    .uie     (ctlB[B_UIE]),
    .aie     (ctlB[B_AIE]),
    .clrUip  (clrUip),
    .cmd     (cmd),
    .uip     (uip),
    .updEnd  (updEnd),
    .alarmChk(alarmChk)
  );

  calclk_time #(
    .ADDR_W(4),
    .DATA_W(8)
  ) u_time (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .cmd     (cmd),
    .dispRegs(dispRegs),
    .ctlALow (ctlALow),
    .ctlB    (ctlB),
    .clrUip  (clrUip)
  );

  assign secReg  = dispRegs.sec;
  assign minReg  = dispRegs.min;
  assign hourReg = dispRegs.hour;
  assign wdayReg = dispRegs.wday;
  assign mdayReg = dispRegs.mday;
  assign monReg  = dispRegs.mon;
  assign yearReg = dispRegs.year;
  assign ctlA    = {uip, ctlALow};

endmodule

// File: rtl/calclk_chk.sv
module calclk_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [7:0] secReg,
  input logic [7:0] minReg,
  input logic [7:0] hourReg,
  input logic [7:0] ctlA,
  input logic [7:0] ctlB,
  input logic       updEnd,
  input logic       alarmChk
);

  // R3
  uip_needs_osc_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctlA[7]) |-> $past(ctlA[6:4]) == 3'b010);

  // R9
  frz_no_uip_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctlB[7] |-> !ctlA[7]);

  // R9
  frz_holds_regs_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctlB[7] && !wrEn) |=> ($stable(secReg) && $stable(minReg) && $stable(hourReg)));

  // R11
  upd_end_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    updEnd |-> ($past(ctlB[4]) && !ctlA[7]));

  // R11
  alarm_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    alarmChk |-> ($past(ctlB[5]) && !ctlA[7]));

  // R11
  upd_end_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    updEnd |=> !updEnd);

endmodule

bind calendar_clock calclk_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .wrEn    (wrEn),
  .secReg  (secReg),
  .minReg  (minReg),
  .hourReg (hourReg),
  .ctlA    (ctlA),
  .ctlB    (ctlB),
  .updEnd  (updEnd),
  .alarmChk(alarmChk)
);

// File: tb/calendar_clock_test.sv
module calendar_clock_test;

  localparam int TPS = 32;
  localparam int CPY = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick32k = 1'b0;
  logic       wrEn = 1'b0;
  logic [3:0] wrAddr = 4'd0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] secReg, minReg, hourReg, wdayReg, mdayReg, monReg, yearReg;
  logic [7:0] ctlA, ctlB;
  logic       updEnd, alarmChk;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  calendar_clock #(.TICKS_PER_SEC(TPS), .COPY_TICKS(CPY)) uut (
    .clk(clk), .rstN(rstN), .tick32k(tick32k),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .secReg(secReg), .minReg(minReg), .hourReg(hourReg), .wdayReg(wdayReg),
    .mdayReg(mdayReg), .monReg(monReg), .yearReg(yearReg),
    .ctlA(ctlA), .ctlB(ctlB), .updEnd(updEnd), .alarmChk(alarmChk)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitUpdate(output int hi, output int nEnd, output int nAlm);
    hi = 0; nEnd = 0; nAlm = 0;
    @(negedge clk);
    while (!ctlA[7]) @(negedge clk);
    while (ctlA[7]) begin
      hi++;
      nEnd += int'(updEnd); nAlm += int'(alarmChk);
      @(negedge clk);
    end
    nEnd += int'(updEnd); nAlm += int'(alarmChk);
    @(negedge clk);
    nEnd += int'(updEnd); nAlm += int'(alarmChk);
  endtask

  task automatic sync();
    int h, e, a;
    waitUpdate(h, e, a);
  endtask

  task automatic setTime(input logic [7:0] mode, input logic [7:0] s, input logic [7:0] mi,
                         input logic [7:0] h, input logic [7:0] wd, input logic [7:0] md,
                         input logic [7:0] mo, input logic [7:0] y);
    sync();
    wrReg(4'd8, mode | 8'h80);
    wrReg(4'd0, s);  wrReg(4'd1, mi); wrReg(4'd2, h);  wrReg(4'd3, wd);
    wrReg(4'd4, md); wrReg(4'd5, mo); wrReg(4'd6, y);
    wrReg(4'd8, mode);
  endtask

  task automatic t_reset();
    chk("R1 sec", secReg, 8'h00);   chk("R1 min", minReg, 8'h00);
    chk("R1 hour", hourReg, 8'h00); chk("R1 wday", wdayReg, 8'h00);
    chk("R1 mday", mdayReg, 8'h01); chk("R1 mon", monReg, 8'h01);
    chk("R1 year", yearReg, 8'h00); chk("R1 ctlA", ctlA, 8'h26);
    chk("R1 ctlB", ctlB, 8'h02);    chk("R1 strobes", {6'd0, updEnd, alarmChk}, 8'h00);
  endtask

  task automatic t_two_phase();
    int hi, e, a;
    setTime(8'h02, 8'h19, 8'h20, 8'h08, 8'h03, 8'h15, 8'h06, 8'h21);
    @(negedge clk);
    while (!ctlA[7]) @(negedge clk);
    chk("R2 old time during update", secReg, 8'h19);
    hi = 0;
    while (ctlA[7]) begin hi++; @(negedge clk); end
    chk("R2 uip width", 8'(hi), 8'(CPY));
    chk("R5 bcd carry sec", secReg, 8'h20);
    chk("R5 min kept", minReg, 8'h20);
    waitUpdate(hi, e, a);
    chk("R2 next second", secReg, 8'h21);
  endtask

  task automatic t_rollover();
    int hi, e, a;
    setTime(8'h02, 8'h59, 8'h59, 8'h23, 8'h06, 8'h31, 8'h12, 8'h99);
    waitUpdate(hi, e, a);
    chk("R5 sec", secReg, 8'h00);  chk("R5 min", minReg, 8'h00);
    chk("R5 hour", hourReg, 8'h00); chk("R12 wday wrap", wdayReg, 8'h00);
    chk("R5 mday", mdayReg, 8'h01); chk("R5 mon", monReg, 8'h01);
    chk("R5 year", yearReg, 8'h00);
  endtask

  task automatic t_binary();
    int hi, e, a;
    setTime(8'h06, 8'd59, 8'd20, 8'd10, 8'd2, 8'd28, 8'd2, 8'd23);
    waitUpdate(hi, e, a);
    chk("R6 sec", secReg, 8'd0); chk("R6 min", minReg, 8'd21);
    chk("R6 hour", hourReg, 8'd10); chk("R6 mday", mdayReg, 8'd28);
    chk("R6 year", yearReg, 8'd23);
  endtask

  task automatic t_12h();
    int hi, e, a;
    setTime(8'h00, 8'h59, 8'h59, 8'h11, 8'h01, 8'h10, 8'h03, 8'h22);
    waitUpdate(hi, e, a);
    chk("R7 noon pm", hourReg, 8'h80); chk("R7 same day", mdayReg, 8'h10);
    setTime(8'h00, 8'h59, 8'h59, 8'h91, 8'h01, 8'h10, 8'h03, 8'h22);
    waitUpdate(hi, e, a);
    chk("R7 midnight", hourReg, 8'h00); chk("R7 pm load next day", mdayReg, 8'h11);
    chk("R7 wday", wdayReg, 8'h02);
  endtask

  task automatic t_leap();
    int hi, e, a;
    setTime(8'h02, 8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h00);
    waitUpdate(hi, e, a);
    chk("R8 2000 day", mdayReg, 8'h29); chk("R8 2000 mon", monReg, 8'h02);
    setTime(8'h02, 8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h24);
    waitUpdate(hi, e, a);
    chk("R8 2024 day", mdayReg, 8'h29);
    setTime(8'h02, 8'h59, 8'h59, 8'h23, 8'h01, 8'h29, 8'h02, 8'h24);
    waitUpdate(hi, e, a);
    chk("R8 2024 end day", mdayReg, 8'h01); chk("R8 2024 end mon", monReg, 8'h03);
    setTime(8'h02, 8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h23);
    waitUpdate(hi, e, a);
    chk("R8 2023 day", mdayReg, 8'h01); chk("R8 2023 mon", monReg, 8'h03);
    setTime(8'h02, 8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h04, 8'h23);
    waitUpdate(hi, e, a);
    chk("R8 april day", mdayReg, 8'h01); chk("R8 april mon", monReg, 8'h05);
  endtask

  task automatic t_osc();
    logic [7:0] s0;
    int seen = 0;
    sync();
    s0 = secReg;
    wrReg(4'd7, 8'h06);
    for (int i = 0; i < 3 * TPS; i++) begin
      @(negedge clk);
      seen += int'(ctlA[7]);
    end
    chk("R3 no uip when stopped", 8'(seen), 8'd0);
    chk("R3 sec frozen", secReg, s0);
    wrReg(4'd7, 8'h26);
  endtask

  task automatic t_ctla();
    sync();
    wrReg(4'd7, 8'hA6);
    chk("R4 uip read only", ctlA, 8'h26);
    wrReg(4'd7, 8'h25);
    chk("R4 low bits written", ctlA, 8'h25);
    wrReg(4'd7, 8'h26);
  endtask

  task automatic t_freeze();
    int hi, e, a;
    int seen = 0;
    setTime(8'h02, 8'h30, 8'h45, 8'h12, 8'h04, 8'h05, 8'h07, 8'h11);
    waitUpdate(hi, e, a);
    wrReg(4'd8, 8'h82);
    wrReg(4'd0, 8'h50);
    for (int i = 0; i < 3 * TPS; i++) begin
      @(negedge clk);
      seen += int'(ctlA[7]);
    end
    chk("R9 no uip while frozen", 8'(seen), 8'd0);
    chk("R9 sec held", secReg, 8'h50);
    chk("R9 min held", minReg, 8'h45);
    wrReg(4'd8, 8'h02);
    waitUpdate(hi, e, a);
    chk("R9 reload on release", secReg, 8'h51);
  endtask

  task automatic t_hostwr();
    int hi, e, a;
    logic [7:0] m0;
    sync();
    m0 = minReg;
    wrReg(4'd0, 8'h40);
    waitUpdate(hi, e, a);
    chk("R10 reload sec", secReg, 8'h41);
    chk("R10 min kept", minReg, m0);
  endtask

  task automatic t_strobes();
    int hi, e, a;
    sync();
    wrReg(4'd8, 8'h12);
    waitUpdate(hi, e, a);
    chk("R11 upd end count", 8'(e), 8'd1); chk("R11 no alarm", 8'(a), 8'd0);
    wrReg(4'd8, 8'h22);
    waitUpdate(hi, e, a);
    chk("R11 no upd end", 8'(e), 8'd0); chk("R11 alarm count", 8'(a), 8'd1);
    wrReg(4'd8, 8'h02);
    waitUpdate(hi, e, a);
    chk("R11 none", 8'(e + a), 8'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    tick32k = 1'b1;
    t_two_phase();
    t_rollover();
    t_binary();
    t_12h();
    t_leap();
    t_osc();
    t_ctla();
    t_freeze();
    t_hostwr();
    t_strobes();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (40000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule